// File: doc/BRIEF.md
# Radix-3 Winograd Butterfly with Block-Floating-Point Output Scaling

This block computes one three-point discrete Fourier transform kernel per valid cycle, for use inside a mixed-radix transform engine that tracks a shared block exponent per layer. Each cycle it accepts three complex samples in signed 1.17 fixed point and two complex twiddle factors. The twiddles are applied to the second and third samples before the butterfly. It also takes a direction flag, the exponent carried in from earlier layers and a right-shift amount of 0 to 3 bits chosen by the layer scaling logic.

The butterfly uses the Winograd form. The sum and the difference of the two rotated samples are formed first. The sum is halved with a plain shift. The difference is multiplied by the single constant 0.866, with its sign chosen by the transform direction. Internal words carry four integer bits and twenty fractional bits, so no intermediate result can overflow. Each output is shifted right by the requested amount and rounded to nearest back to 1.17, with saturation. The outgoing exponent adds the applied shift to the incoming exponent. The top four bits of every output component are also presented, for the neighbouring logic that finds the largest magnitude in a layer.

The pipeline has a fixed depth of four registers. A valid flag travels with the data, and cycles with the flag low leave no result.

Top module: `wino3_bfly`

## Requirements
- R1: After a synchronous active-high reset, out_valid is 0, out_exp is 0 and every output data and nibble bit is 0 until a valid input reaches the output.
- R2: out_valid is high exactly 4 clock edges after each cycle with in_valid high, and at no other time.
- R3: Rotated sample k (k = 1, 2) is x_k times twiddle index k-1. Inputs are in_re/in_im index k; twiddles are tw_re/tw_im index k-1, all 1.17. Its real part is floor((ar*wr - ai*wi) / 2^14) and its imaginary part is floor((ar*wi + ai*wr) / 2^14), both with 20 fractional bits.
- R4: With x0 taken at 20 fractional bits (x0*8), t = y1+y2 and X0 = x0 + t. X0 appears on output index 0.
- R5: With d = y1-y2, P_re = 113512*d_re and P_im = 113512*d_im. When in_fwd = 1, u_re = floor(P_im/2^17) and u_im = floor(-P_re/2^17). With m = x0 - floor(t/2), X1 = m+u appears on index 1 and X2 = m-u on index 2.
- R6: When in_fwd = 0, u_re = floor(-P_im/2^17) and u_im = floor(P_re/2^17), and the other terms are as in R5.
- R7: Each 20-fraction-bit result v is reduced to 1.17 as round(v / 2^(3+s)), where s = in_shift. Ties round away from zero.
- R8: A rounded value above 131071 is output as 131071, and one below -131072 is output as -131072.
- R9: out_top_re[k] and out_top_im[k] equal bits 17:14 of out_re[k] and out_im[k].
- R10: out_exp equals in_exp + in_shift of the same sample, saturated at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample set is valid this cycle |
| in_fwd | input | 1 | 1 = forward transform, 0 = inverse |
| in_exp | input | 4 | Incoming block exponent |
| in_shift | input | 2 | Right shift applied before rounding (0..3) |
| in_re | input | 3x18 | Real parts of x0, x1, x2 (1.17) |
| in_im | input | 3x18 | Imaginary parts of x0, x1, x2 (1.17) |
| tw_re | input | 2x18 | Real parts of twiddles for x1 (index 0) and x2 (index 1) |
| tw_im | input | 2x18 | Imaginary parts of the twiddles |
| out_valid | output | 1 | Output set is valid |
| out_exp | output | 4 | Outgoing block exponent |
| out_re | output | 3x18 | Real parts of X0, X1, X2 (1.17) |
| out_im | output | 3x18 | Imaginary parts of X0, X1, X2 (1.17) |
| out_top_re | output | 3x4 | Top four bits of each real output |
| out_top_im | output | 3x4 | Top four bits of each imaginary output |

## Verification
Random sample sets are swept through every shift amount in both directions. This separates the signs of the constant term between forward and inverse, and shows whether X1 and X2 land on the right indices. Sets with the third sample and x0 at zero expose the twiddle product and its truncation directly on X0. Full-scale and extreme values with large twiddles drive the saturation limits. Sets with only x0 non-zero and odd values produce exact halfway cases, which distinguishes ties away from zero from other rounding rules for both signs. Idle cycles placed between samples and a sweep of incoming exponents check the valid alignment and the exponent limit at 15.

// File: rtl/wino3_pkg.sv
package wino3_pkg;

    // sample format: sign bit plus FRAC fractional bits
    localparam int DW    = 18;
    localparam int FRAC  = DW - 1;
    // internal format: GUARD integer bits, IFRAC fractional bits
    localparam int GUARD = 4;
    localparam int IFRAC = 20;
    localparam int IW    = GUARD + IFRAC;
    // extension from sample fraction to internal fraction
    localparam int EXT   = IFRAC - FRAC;
    // truncation of a full-precision twiddle product
    localparam int TWSH  = 2 * FRAC - IFRAC;
    // exponent and shift control
    localparam int EXPW  = 4;
    localparam int SHW   = 2;
    localparam int NIB   = 4;
    localparam int LAT   = 4;
    // 0.866 with FRAC fractional bits
    localparam logic signed [DW:0] K866 = 19'sd113512;
    // width of the constant product
    localparam int PW    = IW + DW + 2;

    typedef logic signed [IW-1:0] acc_t;

    typedef struct packed {
        acc_t re;
        acc_t im;
    } cacc_t;

    typedef struct packed {
        logic            vld;
        logic            fwd;
        logic [EXPW-1:0] bexp;
        logic [SHW-1:0]  sh;
    } ctl_t;

    // exponent plus shift, clipped at the all-ones value
    function automatic logic [EXPW-1:0] exp_add(input logic [EXPW-1:0] e,
                                               input logic [SHW-1:0] s);
        logic [EXPW:0] sum;
        sum = {1'b0, e} + {{(EXPW + 1 - SHW){1'b0}}, s};
        if (sum[EXPW]) return '1;
        return sum[EXPW-1:0];
    endfunction

    // widen a 1.17 sample to the internal format
    function automatic acc_t widen(input logic [DW-1:0] x);
        acc_t w;
        w = {{(IW - DW){x[DW-1]}}, x} <<< EXT;
        return w;
    endfunction

endpackage

// File: rtl/wino3_twmul.sv
module wino3_twmul
    import wino3_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] w_re,
    input  logic signed [DW-1:0] w_im,
    output cacc_t                y
);

    logic signed [2*DW:0] p_re;
    logic signed [2*DW:0] p_im;

    always_comb begin
        p_re = a_re * w_re - a_im * w_im;
        p_im = a_re * w_im + a_im * w_re;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y <= '0;
        end else if (vld) begin
            y.re <= acc_t'(p_re >>> TWSH);
            y.im <= acc_t'(p_im >>> TWSH);
        end
    end

    // R3: a zero twiddle leaves a zero rotated sample
    a_r3_zero_twiddle: assert property (@(posedge clk) disable iff (rst)
        (vld && w_re == '0 && w_im == '0) |=> (y.re == '0 && y.im == '0));

endmodule

// File: rtl/wino3_core.sv
module wino3_core
    import wino3_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctl_t  c1,
    input  cacc_t x0_1,
    input  cacc_t y1_1,
    input  cacc_t y2_1,
    output ctl_t  c3,
    output cacc_t x0_3,
    output cacc_t m_3,
    output cacc_t u_3
);

    // second stage: sum and difference of the rotated samples
    ctl_t  c2;
    cacc_t x0_2;
    cacc_t t_2;
    cacc_t d_2;

    always_ff @(posedge clk) begin
        if (rst) begin
            c2   <= '0;
            x0_2 <= '0;
            t_2  <= '0;
            d_2  <= '0;
        end else begin
            c2 <= c1;
            if (c1.vld) begin
                x0_2    <= x0_1;
                t_2.re  <= y1_1.re + y2_1.re;
                t_2.im  <= y1_1.im + y2_1.im;
                d_2.re  <= y1_1.re - y2_1.re;
                d_2.im  <= y1_1.im - y2_1.im;
            end
        end
    end

    // third stage: DC term, mid term and rotated constant term
    logic signed [PW-1:0] pr;
    logic signed [PW-1:0] pi;
    logic signed [PW-1:0] ur_full;
    logic signed [PW-1:0] ui_full;
    cacc_t x0_n;
    cacc_t m_n;
    cacc_t u_n;

    always_comb begin
        pr = d_2.re * K866;
        pi = d_2.im * K866;
        if (c2.fwd) begin
            ur_full = pi;
            ui_full = -pr;
        end else begin
            ur_full = -pi;
            ui_full = pr;
        end
        u_n.re  = acc_t'(ur_full >>> FRAC);
        u_n.im  = acc_t'(ui_full >>> FRAC);
        x0_n.re = x0_2.re + t_2.re;
        x0_n.im = x0_2.im + t_2.im;
        m_n.re  = x0_2.re - (t_2.re >>> 1);
        m_n.im  = x0_2.im - (t_2.im >>> 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c3   <= '0;
            x0_3 <= '0;
            m_3  <= '0;
            u_3  <= '0;
        end else begin
            c3 <= c2;
            if (c2.vld) begin
                x0_3 <= x0_n;
                m_3  <= m_n;
                u_3  <= u_n;
            end
        end
    end

    // R6: equal rotated samples give no constant-term contribution
    a_r6_no_diff: assert property (@(posedge clk) disable iff (rst)
        (c2.vld && d_2.re == '0 && d_2.im == '0) |=> (u_3.re == '0 && u_3.im == '0));

endmodule

// File: rtl/wino3_quant.sv
module wino3_quant
    import wino3_pkg::*;
(
    input  acc_t                 v,
    input  logic [SHW-1:0]       sh,
    output logic signed [DW-1:0] q
);

    localparam int QW = IW + 2;
    localparam logic signed [QW-1:0] QMAX = QW'((2 ** FRAC) - 1);
    localparam logic signed [QW-1:0] QMIN = -QW'(2 ** FRAC);

    logic signed [QW-1:0] vx;
    logic signed [QW-1:0] mag;
    logic signed [QW-1:0] sum;
    logic signed [QW-1:0] qm;
    logic signed [QW-1:0] rq;
    logic                 neg;

    always_comb begin
        vx  = {{2{v[IW-1]}}, v};
        neg = vx[QW-1];
        mag = neg ? -vx : vx;
        sum = mag + (QW'(1) << (EXT - 1 + int'(sh)));
        qm  = sum >>> (EXT + int'(sh));
        rq  = neg ? -qm : qm;
        if (rq > QMAX) begin
            q = QMAX[DW-1:0];
        end else if (rq < QMIN) begin
            q = QMIN[DW-1:0];
        end else begin
            q = rq[DW-1:0];
        end
    end

endmodule

// File: rtl/wino3_bfly.sv
module wino3_bfly
    import wino3_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_fwd,
    input  logic [3:0]           in_exp,
    input  logic [1:0]           in_shift,
    input  logic [2:0][17:0]     in_re,
    input  logic [2:0][17:0]     in_im,
    input  logic [1:0][17:0]     tw_re,
    input  logic [1:0][17:0]     tw_im,
    output logic                 out_valid,
    output logic [3:0]           out_exp,
    output logic [2:0][17:0]     out_re,
    output logic [2:0][17:0]     out_im,
    output logic [2:0][3:0]      out_top_re,
    output logic [2:0][3:0]      out_top_im
);

    localparam int NPT = 3;
    localparam int NTW = NPT - 1;

    // first stage: control, widened x0 and twiddle products
    ctl_t  c1;
    cacc_t x0_1;
    cacc_t y_1 [NTW];

    always_ff @(posedge clk) begin
        if (rst) begin
            c1   <= '0;
            x0_1 <= '0;
        end else begin
            c1.vld  <= in_valid;
            c1.fwd  <= in_fwd;
            c1.bexp <= in_exp;
            c1.sh   <= in_shift;
            if (in_valid) begin
                x0_1.re <= widen(in_re[0]);
                x0_1.im <= widen(in_im[0]);
            end
        end
    end

    for (genvar k = 0; k < NTW; k++) begin : g_tw
        wino3_twmul u_tw (
            .clk  (clk),
            .rst  (rst),
            .vld  (in_valid),
            .a_re ($signed(in_re[k+1])),
            .a_im ($signed(in_im[k+1])),
            .w_re ($signed(tw_re[k])),
            .w_im ($signed(tw_im[k])),
            .y    (y_1[k])
        );
    end

    // second and third stages
    ctl_t  c3;
    cacc_t x0_3;
    cacc_t m_3;
    cacc_t u_3;

    wino3_core u_core (
        .clk  (clk),
        .rst  (rst),
        .c1   (c1),
        .x0_1 (x0_1),
        .y1_1 (y_1[0]),
        .y2_1 (y_1[1]),
        .c3   (c3),
        .x0_3 (x0_3),
        .m_3  (m_3),
        .u_3  (u_3)
    );

    // fourth stage: final adds, scaling, rounding, saturation
    cacc_t pre [NPT];

    always_comb begin
        pre[0]    = x0_3;
        pre[1].re = m_3.re + u_3.re;
        pre[1].im = m_3.im + u_3.im;
        pre[2].re = m_3.re - u_3.re;
        pre[2].im = m_3.im - u_3.im;
    end

    logic signed [DW-1:0] q_re [NPT];
    logic signed [DW-1:0] q_im [NPT];

    for (genvar k = 0; k < NPT; k++) begin : g_q
        wino3_quant u_qr (
            .v  (pre[k].re),
            .sh (c3.sh),
            .q  (q_re[k])
        );
        wino3_quant u_qi (
            .v  (pre[k].im),
            .sh (c3.sh),
            .q  (q_im[k])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                out_re[k]     <= '0;
                out_im[k]     <= '0;
                out_top_re[k] <= '0;
                out_top_im[k] <= '0;
            end else if (c3.vld) begin
                out_re[k]     <= q_re[k];
                out_im[k]     <= q_im[k];
                out_top_re[k] <= q_re[k][DW-1 -: NIB];
                out_top_im[k] <= q_im[k][DW-1 -: NIB];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_exp   <= '0;
        end else begin
            out_valid <= c3.vld;
            if (c3.vld) out_exp <= exp_add(c3.bexp, c3.sh);
        end
    end

    // cycles since reset, saturating at the pipeline depth
    logic [2:0] age;
    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 3'(LAT)) age <= age + 3'd1;
    end

    // R2: valid emerges four edges after it enters
    a_r2_valid_lat: assert property (@(posedge clk) disable iff (rst)
        (age == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    // R10: outgoing exponent tracks the sample it belongs to
    a_r10_exp_sum: assert property (@(posedge clk) disable iff (rst)
        (age == 3'd4 && out_valid) |->
        (out_exp == exp_add($past(in_exp, 4), $past(in_shift, 4))));

endmodule

// File: tb/wino3_bfly_tb.sv
module wino3_bfly_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2048;
    localparam int WATCHDOG   = 100000;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic            in_fwd;
    logic [3:0]      in_exp;
    logic [1:0]      in_shift;
    logic [2:0][17:0] in_re;
    logic [2:0][17:0] in_im;
    logic [1:0][17:0] tw_re;
    logic [1:0][17:0] tw_im;
    logic            out_valid;
    logic [3:0]      out_exp;
    logic [2:0][17:0] out_re;
    logic [2:0][17:0] out_im;
    logic [2:0][3:0] out_top_re;
    logic [2:0][3:0] out_top_im;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wino3_bfly dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_fwd(in_fwd),
        .in_exp(in_exp), .in_shift(in_shift), .in_re(in_re), .in_im(in_im),
        .tw_re(tw_re), .tw_im(tw_im), .out_valid(out_valid), .out_exp(out_exp),
        .out_re(out_re), .out_im(out_im), .out_top_re(out_top_re),
        .out_top_im(out_top_im)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int wr     = 0;
    int rd     = 0;
    bit running = 0;
    bit done    = 0;
    bit [31:0] seed = 32'h1234_5678;

    int e_val [DEPTH][6];
    int e_tag [DEPTH][6];
    int e_exp [DEPTH];
    int e_cyc [DEPTH];

    int xr [3];
    int xi [3];
    int wre [2];
    int wim [2];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic string tname(input int c);
        case (c)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input int tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tname(tag), what, act, exp);
        end
    endtask

    function automatic int rnd18();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'($signed(seed[30:13]));
    endfunction

    function automatic int pick_ext();
        seed = seed * 32'd1103515245 + 32'd12345;
        case (seed[29:28])
            2'd0: return 131071;
            2'd1: return -131072;
            2'd2: return 131071;
            default: return -131072;
        endcase
    endfunction

    // R7 and R8: shift, round half away from zero, clip
    function automatic int rsat(input longint v, input int s, output bit clip);
        longint mag, q, r;
        int sh;
        sh   = 3 + s;
        mag  = (v < 0) ? -v : v;
        q    = (mag + (64'sd1 <<< (sh - 1))) >>> sh;
        r    = (v < 0) ? -q : q;
        clip = 1'b0;
        if (r > 131071)  begin r = 131071;  clip = 1'b1; end
        if (r < -131072) begin r = -131072; clip = 1'b1; end
        return int'(r);
    endfunction

    // push one valid sample set and its expected result
    task automatic push(input bit fwd, input int sh, input int ex, input int pat);
        longint yr [3];
        longint yi [3];
        longint x0r, x0i, tr, ti, dr, di, pr, pi, ur, ui, mr, mi;
        longint v [6];
        bit clip;
        for (int k = 1; k < 3; k++) begin
            // R3: rotated samples, floor to 20 fraction bits
            yr[k] = (longint'(xr[k]) * wre[k-1] - longint'(xi[k]) * wim[k-1]) >>> 14;
            yi[k] = (longint'(xr[k]) * wim[k-1] + longint'(xi[k]) * wre[k-1]) >>> 14;
        end
        x0r = longint'(xr[0]) * 8;
        x0i = longint'(xi[0]) * 8;
        tr = yr[1] + yr[2];  ti = yi[1] + yi[2];
        dr = yr[1] - yr[2];  di = yi[1] - yi[2];
        pr = 64'sd113512 * dr;
        pi = 64'sd113512 * di;
        if (fwd) begin ur = pi >>> 17;    ui = (-pr) >>> 17; end
        else     begin ur = (-pi) >>> 17; ui = pr >>> 17;    end
        mr = x0r - (tr >>> 1);
        mi = x0i - (ti >>> 1);
        v[0] = x0r + tr; v[1] = x0i + ti;
        v[2] = mr + ur;  v[3] = mi + ui;
        v[4] = mr - ur;  v[5] = mi - ui;
        for (int j = 0; j < 6; j++) begin
            e_val[wr][j] = rsat(v[j], sh, clip);
            if (clip)          e_tag[wr][j] = 8;
            else if (pat == 2) e_tag[wr][j] = 3;
            else if (pat == 3) e_tag[wr][j] = 7;
            else if (j < 2)    e_tag[wr][j] = 4;
            else               e_tag[wr][j] = fwd ? 5 : 6;
        end
        e_exp[wr] = (ex + sh > 15) ? 15 : ex + sh;
        e_cyc[wr] = cyc;
        for (int k = 0; k < 3; k++) begin
            in_re[k] = xr[k][17:0];
            in_im[k] = xi[k][17:0];
        end
        for (int k = 0; k < 2; k++) begin
            tw_re[k] = wre[k][17:0];
            tw_im[k] = wim[k][17:0];
        end
        in_valid = 1'b1;
        in_fwd   = fwd;
        in_exp   = 4'(ex);
        in_shift = 2'(sh);
        wr++;
        @(negedge clk);
    endtask

    task automatic bubble();
        in_valid = 1'b0;
        in_re    = {3{18'h2AAAA}};
        in_im    = {3{18'h15555}};
        in_exp   = 4'hF;
        in_shift = 2'd3;
        @(negedge clk);
    endtask

    task automatic make_vec(input int pat);
        case (pat)
            0: begin
                for (int k = 0; k < 3; k++) begin xr[k] = rnd18(); xi[k] = rnd18(); end
                for (int k = 0; k < 2; k++) begin wre[k] = rnd18(); wim[k] = rnd18(); end
            end
            1: begin
                for (int k = 0; k < 3; k++) begin xr[k] = pick_ext(); xi[k] = pick_ext(); end
                for (int k = 0; k < 2; k++) begin wre[k] = pick_ext(); wim[k] = pick_ext(); end
            end
            2: begin
                xr[0] = 0; xi[0] = 0; xr[2] = 0; xi[2] = 0;
                xr[1] = rnd18(); xi[1] = rnd18();
                wre[0] = rnd18(); wim[0] = rnd18();
                wre[1] = rnd18(); wim[1] = rnd18();
            end
            default: begin
                // odd x0 with nothing else gives exact halfway points
                xr[0] = rnd18() | 1; xi[0] = rnd18() | 1;
                for (int k = 1; k < 3; k++) begin xr[k] = 0; xi[k] = 0; end
                for (int k = 0; k < 2; k++) begin wre[k] = rnd18(); wim[k] = rnd18(); end
            end
        endcase
    endtask

    // output monitor
    always @(negedge clk) begin
        if (running && !rst) begin
            if (out_valid) begin
                if (rd >= wr) begin
                    check(1'b0, 2, "unexpected out_valid", 1, 0);
                end else begin
                    int act [6];
                    int nib_a, nib_e;
                    check(cyc - e_cyc[rd] == 4, 2, "latency", cyc - e_cyc[rd], 4);
                    for (int k = 0; k < 3; k++) begin
                        act[2*k]   = int'($signed(out_re[k]));
                        act[2*k+1] = int'($signed(out_im[k]));
                    end
                    nib_a = 0; nib_e = 0;
                    for (int j = 0; j < 6; j++) begin
                        check(act[j] == e_val[rd][j], e_tag[rd][j],
                              $sformatf("data idx %0d comp %0d", rd, j),
                              act[j], e_val[rd][j]);
                        nib_e = (nib_e << 4) | ((e_val[rd][j] >>> 14) & 15);
                    end
                    for (int k = 0; k < 3; k++) begin
                        nib_a = (nib_a << 8) | (int'(out_top_re[k]) << 4) | int'(out_top_im[k]);
                    end
                    // R9: nibbles are bits 17:14 of each output
                    check(nib_a == nib_e, 9, "top nibbles", nib_a, nib_e);
                    // R10: saturating exponent sum
                    check(int'(out_exp) == e_exp[rd], 10, "exponent", out_exp, e_exp[rd]);
                    rd++;
                end
            end else if (rd < wr && cyc - e_cyc[rd] >= 4) begin
                check(1'b0, 2, "missing out_valid", 0, 1);
                rd++;
            end
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1;
        in_valid = 1'b0; in_fwd = 1'b0; in_exp = '0; in_shift = '0;
        in_re = '0; in_im = '0; tw_re = '0; tw_im = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, 1, "out_valid after reset", out_valid, 0);
        check(out_exp == 4'd0, 1, "out_exp after reset", out_exp, 0);
        check(out_re == '0 && out_im == '0, 1, "data after reset", 1, 0);
        check(out_top_re == '0 && out_top_im == '0, 1, "nibbles after reset", 1, 0);
        running = 1'b1;
        for (int pat = 0; pat < 4; pat++) begin
            for (int sh = 0; sh < 4; sh++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    for (int n = 0; n < 40; n++) begin
                        make_vec(pat);
                        push(dir[0], sh, (n + sh * 5) % 16, pat);
                        if (n % 7 == 3) bubble();
                    end
                end
            end
        end
        bubble();
        repeat (10) @(negedge clk);
        // R2: every pushed set came out
        check(rd == wr, 2, "outputs drained", rd, wr);
        summary();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", rd, wr);
        summary();
    end

endmodule